// File: doc/BRIEF.md
# PCI Function State Controller

This block keeps the lifecycle state of a small pool of PCI functions and answers management requests for them. Each request names a function by its function ID and an operation: allocate a slot, configure, deconfigure, reset, enable, raise a fault, set the release timeout, or hot-unplug. Every request gets exactly one 16-bit response code together with the function's handle. The handle is the slot index with an enable flag on its most significant bit.

State changes that the host must hear about are posted on a one-cycle event port. These are the start of an unplug, a timed-out unplug, and the final release to reserved. The block does not tear down interrupts or address translation itself. Whenever a function leaves an active state it pulses two deregister strobes for those units, tagged with the function ID.

A hot unplug of an active function is a two-phase handshake. The block posts a request event and starts a per-function release counter. If the host deconfigures the function first, the unplug finishes at once. If the counter runs out, the block forces the function down by itself.

Top module: `pcifn_state_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_done, evt_valid and both deregister strobes are 0, and no slot is in use: any request other than allocate returns 0x0040 (unknown ID) with handle 0.
- R2: Allocate (op 4) probes slot indices upward from a next-index pointer and wraps within the index width. The first free slot is taken and the pointer becomes that index plus one. The response is 0x0010 with handle {0, index}. The new function starts in standby if req_arg[0] is 1 and in reserved otherwise. An ID already in use returns 0x0020 (no action). A full pool returns 0x0050 (no slot).
- R3: A request is taken on a clock edge where req_valid and req_ready are both 1. rsp_done is 1 for exactly one cycle, after the second edge following the taking edge. req_ready is 0 in between.
- R4: Configure (op 0) returns 0x0030 from reserved. From standby it moves the function to disabled and returns 0x0010. From every other state it returns 0x0020.
- R5: Deconfigure (op 1) returns 0x0030 from reserved and 0x0020 from standby. From any other state it pulses dereg_irq and dereg_xlat with dereg_fid set to the ID, moves the function to standby, clears the enable flag and returns 0x0010, all in the rsp_done cycle.
- R6: If a successful deconfigure finds the function's release counter running, it stops the counter and posts event 0x0103 (standby to reserved) in the rsp_done cycle. The function is then released, and its ID becomes unknown. No timeout event follows.
- R7: Unplug (op 3) of a function that is not reserved or standby returns 0x0060 (pending) and posts event 0x0101 (deconfigure request) in the rsp_done cycle. It also starts the function's release counter.
- R8: When a release counter of T cycles runs out, event 0x0102 (configured to standby) appears with both deregister strobes T+2 cycles after the rsp_done cycle of the unplug. Event 0x0103 follows in the next cycle, and the function is then released.
- R9: Unplug of a standby function returns 0x0010, posts event 0x0103 and releases the function. Unplug of a reserved function returns 0x0010 and releases it without an event.
- R10: Reset (op 2) returns 0x0030 from reserved and 0x0020 from standby, and leaves both unchanged. From any other state it clears the enable flag, moves to disabled and returns 0x0010.
- R11: Enable (op 5) from disabled moves to enabled, sets the handle enable flag and returns 0x0010. It returns 0x0030 from reserved and 0x0020 from every other state.
- R12: Fault (op 6) moves enabled to blocked and blocked to error, returning 0x0010 for each step. It returns 0x0030 from reserved and 0x0020 from all other states.
- R13: Set-timeout (op 7) stores req_arg as the function's release count, with 0 taken as 1, and returns 0x0010. A newly allocated function uses the TMO_DEF parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_fid | input | FID_W | Function ID addressed |
| req_arg | input | TMR_W | Argument: start state for allocate, count for set-timeout |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_code | output | 16 | Response code |
| rsp_handle | output | IDX_W+1 | {enable flag, slot index} after the operation |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 16 | Event code |
| evt_fid | output | FID_W | Function ID of the event |
| evt_handle | output | IDX_W+1 | Handle of the event's function |
| dereg_irq | output | 1 | Interrupt deregister pulse |
| dereg_xlat | output | 1 | Translation deregister pulse |
| dereg_fid | output | FID_W | Function ID for the deregister pulses |

## Verification
The response, with any event and deregister pulse that belongs to it, is due two edges after the taking edge. The bench checks each request at the falling edge that follows: the first falling edge must still show rsp_done low and req_ready low, and the second must show the response. A timed-out unplug is due T+2 cycles after the unplug's response, and the release event one cycle later. The bench counts falling edges from the response sample and compares the count with T+2. A cancelled counter is checked by watching the event port for longer than the default timeout.

// File: rtl/pcifn_pkg.sv
package pcifn_pkg;

  typedef enum logic [2:0] {
    FS_RESERVED = 3'd0,
    FS_STANDBY  = 3'd1,
    FS_DISABLED = 3'd2,
    FS_ENABLED  = 3'd3,
    FS_BLOCKED  = 3'd4,
    FS_ERROR    = 3'd5
  } fn_state_e;

  typedef enum logic [2:0] {
    OP_CONFIG   = 3'd0,
    OP_DECONFIG = 3'd1,
    OP_RESET    = 3'd2,
    OP_UNPLUG   = 3'd3,
    OP_ALLOC    = 3'd4,
    OP_ENABLE   = 3'd5,
    OP_FAULT    = 3'd6,
    OP_SET_TMO  = 3'd7
  } fn_op_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_EXEC = 2'd1,
    C_EXP1 = 2'd2,
    C_EXP2 = 2'd3
  } ctl_e;

  localparam logic [15:0] RC_OK      = 16'h0010;
  localparam logic [15:0] RC_NOACT   = 16'h0020;
  localparam logic [15:0] RC_RSVD    = 16'h0030;
  localparam logic [15:0] RC_UNKNOWN = 16'h0040;
  localparam logic [15:0] RC_NOSLOT  = 16'h0050;
  localparam logic [15:0] RC_PENDING = 16'h0060;

  localparam logic [15:0] EV_DECONF_REQ   = 16'h0101;
  localparam logic [15:0] EV_CFG_TO_STBY  = 16'h0102;
  localparam logic [15:0] EV_STBY_TO_RSVD = 16'h0103;

  function automatic logic fn_is_active(input fn_state_e s);
    return !(s == FS_RESERVED || s == FS_STANDBY);
  endfunction

endpackage

// File: rtl/pcifn_lookup.sv
module pcifn_lookup #(
  parameter int IDX_W = 2,
  parameter int FID_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [(1<<IDX_W)-1:0]            slot_vld,
  input  logic [(1<<IDX_W)-1:0][FID_W-1:0] slot_fid,
  input  logic [FID_W-1:0]                 key,
  output logic                             hit,
  output logic [IDX_W-1:0]                 idx
);
  localparam int NFUNC = 1 << IDX_W;

  logic [NFUNC-1:0] match;

  always_comb begin
    for (int i = 0; i < NFUNC; i++) begin
      match[i] = slot_vld[i] && (slot_fid[i] == key);
    end
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = NFUNC - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  AST_FID_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R2

endmodule

// File: rtl/pcifn_idx_alloc.sv
module pcifn_idx_alloc #(
  parameter int IDX_W = 2
) (
  input  logic [(1<<IDX_W)-1:0] used,
  input  logic [IDX_W-1:0]      start,
  output logic                  ok,
  output logic [IDX_W-1:0]      idx
);
  localparam int NFUNC = 1 << IDX_W;

  function automatic logic [IDX_W:0] probe_free(input logic [NFUNC-1:0] u,
                                                input logic [IDX_W-1:0] s);
    logic             found;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] cand;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NFUNC; k++) begin
      cand = s + IDX_W'(k);
      if (!found && !u[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
    return {found, pick};
  endfunction

  always_comb begin
    {ok, idx} = probe_free(used, start);
  end

endmodule

// File: rtl/pcifn_release_timer.sv
module pcifn_release_timer #(
  parameter int IDX_W = 2,
  parameter int TMR_W = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [(1<<IDX_W)-1:0]            arm,
  input  logic [(1<<IDX_W)-1:0]            cancel,
  input  logic [(1<<IDX_W)-1:0]            ack,
  input  logic [(1<<IDX_W)-1:0][TMR_W-1:0] load,
  output logic [(1<<IDX_W)-1:0]            run,
  output logic [(1<<IDX_W)-1:0]            pend
);
  localparam int NFUNC = 1 << IDX_W;

  for (genvar g = 0; g < NFUNC; g++) begin : g_slot
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt     <= '0;
        run[g]  <= 1'b0;
        pend[g] <= 1'b0;
      end else if (cancel[g]) begin
        run[g]  <= 1'b0;
        pend[g] <= 1'b0;
      end else if (arm[g]) begin
        cnt     <= load[g];
        run[g]  <= 1'b1;
        pend[g] <= 1'b0;
      end else if (ack[g]) begin
        pend[g] <= 1'b0;
      end else if (run[g]) begin
        if (cnt <= TMR_W'(1)) begin
          run[g]  <= 1'b0;
          pend[g] <= 1'b1;
        end else begin
          cnt <= cnt - TMR_W'(1);
        end
      end
    end

    AST_EXPIRE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) $rose(pend[g]) |-> $past(run[g])); // R8
    AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (arm[g] && !cancel[g]) |=> run[g]); // R7
    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cancel[g] |=> (!run[g] && !pend[g])); // R6
  end

endmodule

// File: rtl/pcifn_state_ctrl.sv
module pcifn_state_ctrl
  import pcifn_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int FID_W   = 8,
  parameter int TMR_W   = 12,
  parameter int TMO_DEF = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [FID_W-1:0] req_fid,
  input  logic [TMR_W-1:0] req_arg,
  output logic             rsp_done,
  output logic [15:0]      rsp_code,
  output logic [IDX_W:0]   rsp_handle,
  output logic             evt_valid,
  output logic [15:0]      evt_code,
  output logic [FID_W-1:0] evt_fid,
  output logic [IDX_W:0]   evt_handle,
  output logic             dereg_irq,
  output logic             dereg_xlat,
  output logic [FID_W-1:0] dereg_fid
);
  localparam int NFUNC = 1 << IDX_W;
  localparam logic [TMR_W-1:0] TMO_INIT = (TMO_DEF < 1) ? TMR_W'(1) : TMR_W'(TMO_DEF);

  function automatic logic [TMR_W-1:0] clamp_tmo(input logic [TMR_W-1:0] v);
    return (v == '0) ? TMR_W'(1) : v;
  endfunction

  // per-slot state
  logic [NFUNC-1:0]            slot_vld;
  logic [NFUNC-1:0][FID_W-1:0] slot_fid;
  logic [NFUNC-1:0]            slot_en;
  logic [NFUNC-1:0][TMR_W-1:0] slot_tmo;
  fn_state_e                   slot_st [NFUNC];
  logic [IDX_W-1:0]            next_idx;

  // control
  ctl_e             ctl;
  fn_op_e           cmd_op;
  logic [FID_W-1:0] cmd_fid;
  logic [TMR_W-1:0] cmd_arg;
  logic [IDX_W-1:0] exp_idx;

  // named internal events
  logic             req_accept;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic             al_ok;
  logic [IDX_W-1:0] al_idx;
  logic [NFUNC-1:0] tmr_run, tmr_pend, arm_v, cancel_v, ack_v;
  logic             exp_any;
  logic [IDX_W-1:0] exp_pick;

  pcifn_lookup #(.IDX_W(IDX_W), .FID_W(FID_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_fid(slot_fid),
    .key(cmd_fid), .hit(lk_hit), .idx(lk_idx)
  );

  pcifn_idx_alloc #(.IDX_W(IDX_W)) u_alloc (
    .used(slot_vld), .start(next_idx), .ok(al_ok), .idx(al_idx)
  );

  pcifn_release_timer #(.IDX_W(IDX_W), .TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm_v), .cancel(cancel_v), .ack(ack_v),
    .load(slot_tmo), .run(tmr_run), .pend(tmr_pend)
  );

  always_comb begin
    exp_any  = |tmr_pend;
    exp_pick = '0;
    for (int i = NFUNC - 1; i >= 0; i--) begin
      if (tmr_pend[i]) exp_pick = IDX_W'(i);
    end
  end

  assign req_ready  = (ctl == C_IDLE) && !exp_any;
  assign req_accept = req_valid && req_ready;

  // decision for the latched request
  fn_state_e        cur_st, x_st;
  logic             x_wr_st, x_set_en, x_clr_en, x_remove, x_alloc;
  logic             x_arm, x_cancel, x_evt, x_dereg, x_settmo;
  logic [15:0]      x_rc, x_evt_code;
  logic [IDX_W:0]   x_hnd;
  logic             new_en;

  always_comb begin
    cur_st     = slot_st[lk_idx];
    x_st       = cur_st;
    x_wr_st    = 1'b0;
    x_set_en   = 1'b0;
    x_clr_en   = 1'b0;
    x_remove   = 1'b0;
    x_alloc    = 1'b0;
    x_arm      = 1'b0;
    x_cancel   = 1'b0;
    x_evt      = 1'b0;
    x_dereg    = 1'b0;
    x_settmo   = 1'b0;
    x_evt_code = EV_DECONF_REQ;
    x_rc       = RC_UNKNOWN;
    if (cmd_op == OP_ALLOC) begin
      if (lk_hit)      x_rc = RC_NOACT;
      else if (!al_ok) x_rc = RC_NOSLOT;
      else begin
        x_rc    = RC_OK;
        x_alloc = 1'b1;
      end
    end else if (lk_hit) begin
      if (cur_st == FS_RESERVED && cmd_op != OP_UNPLUG && cmd_op != OP_SET_TMO) begin
        x_rc = RC_RSVD;
      end else begin
        unique case (cmd_op)
          OP_CONFIG: begin
            if (cur_st == FS_STANDBY) begin
              x_st = FS_DISABLED; x_wr_st = 1'b1; x_rc = RC_OK;
            end else x_rc = RC_NOACT;
          end
          OP_DECONFIG: begin
            if (cur_st == FS_STANDBY) x_rc = RC_NOACT;
            else begin
              x_rc = RC_OK; x_dereg = 1'b1; x_clr_en = 1'b1;
              x_st = FS_STANDBY; x_wr_st = 1'b1;
              if (tmr_run[lk_idx]) begin
                x_evt = 1'b1; x_evt_code = EV_STBY_TO_RSVD; x_remove = 1'b1;
              end
            end
          end
          OP_RESET: begin
            if (cur_st == FS_STANDBY) x_rc = RC_NOACT;
            else begin
              x_rc = RC_OK; x_clr_en = 1'b1; x_st = FS_DISABLED; x_wr_st = 1'b1;
            end
          end
          OP_UNPLUG: begin
            if (cur_st == FS_RESERVED) begin
              x_rc = RC_OK; x_remove = 1'b1;
            end else if (cur_st == FS_STANDBY) begin
              x_rc = RC_OK; x_remove = 1'b1;
              x_evt = 1'b1; x_evt_code = EV_STBY_TO_RSVD;
            end else begin
              x_rc = RC_PENDING; x_arm = 1'b1;
              x_evt = 1'b1; x_evt_code = EV_DECONF_REQ;
            end
          end
          OP_ENABLE: begin
            if (cur_st == FS_DISABLED) begin
              x_rc = RC_OK; x_set_en = 1'b1; x_st = FS_ENABLED; x_wr_st = 1'b1;
            end else x_rc = RC_NOACT;
          end
          OP_FAULT: begin
            if (cur_st == FS_ENABLED) begin
              x_rc = RC_OK; x_st = FS_BLOCKED; x_wr_st = 1'b1;
            end else if (cur_st == FS_BLOCKED) begin
              x_rc = RC_OK; x_st = FS_ERROR; x_wr_st = 1'b1;
            end else x_rc = RC_NOACT;
          end
          OP_SET_TMO: begin
            x_rc = RC_OK; x_settmo = 1'b1;
          end
          default: x_rc = RC_UNKNOWN;
        endcase
      end
    end
    x_cancel = x_remove;

    new_en = x_set_en ? 1'b1 : (x_clr_en ? 1'b0 : slot_en[lk_idx]);
    if (cmd_op == OP_ALLOC) begin
      if (lk_hit)     x_hnd = {slot_en[lk_idx], lk_idx};
      else if (al_ok) x_hnd = {1'b0, al_idx};
      else            x_hnd = '0;
    end else if (!lk_hit) x_hnd = '0;
    else if (x_remove)    x_hnd = {1'b0, lk_idx};
    else                  x_hnd = {new_en, lk_idx};
  end

  always_comb begin
    arm_v    = '0;
    cancel_v = '0;
    ack_v    = '0;
    if (ctl == C_EXEC) begin
      if (x_arm)    arm_v[lk_idx]    = 1'b1;
      if (x_cancel) cancel_v[lk_idx] = 1'b1;
    end
    if (ctl == C_IDLE && exp_any) ack_v[exp_pick] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl        <= C_IDLE;
      cmd_op     <= OP_CONFIG;
      cmd_fid    <= '0;
      cmd_arg    <= '0;
      exp_idx    <= '0;
      next_idx   <= '0;
      slot_vld   <= '0;
      slot_fid   <= '0;
      slot_en    <= '0;
      slot_tmo   <= '0;
      for (int i = 0; i < NFUNC; i++) slot_st[i] <= FS_RESERVED;
      rsp_done   <= 1'b0;
      rsp_code   <= '0;
      rsp_handle <= '0;
      evt_valid  <= 1'b0;
      evt_code   <= '0;
      evt_fid    <= '0;
      evt_handle <= '0;
      dereg_irq  <= 1'b0;
      dereg_xlat <= 1'b0;
      dereg_fid  <= '0;
    end else begin
      rsp_done   <= 1'b0;
      evt_valid  <= 1'b0;
      dereg_irq  <= 1'b0;
      dereg_xlat <= 1'b0;
      unique case (ctl)
        C_IDLE: begin
          if (exp_any) begin
            exp_idx <= exp_pick;
            ctl     <= C_EXP1;
          end else if (req_accept) begin
            cmd_op  <= fn_op_e'(req_op);
            cmd_fid <= req_fid;
            cmd_arg <= req_arg;
            ctl     <= C_EXEC;
          end
        end
        C_EXEC: begin
          rsp_done   <= 1'b1;
          rsp_code   <= x_rc;
          rsp_handle <= x_hnd;
          if (x_evt) begin
            evt_valid  <= 1'b1;
            evt_code   <= x_evt_code;
            evt_fid    <= cmd_fid;
            evt_handle <= x_hnd;
          end
          if (x_dereg) begin
            dereg_irq  <= 1'b1;
            dereg_xlat <= 1'b1;
            dereg_fid  <= cmd_fid;
          end
          if (x_wr_st) slot_st[lk_idx] <= x_st;
          if (x_set_en) slot_en[lk_idx] <= 1'b1;
          if (x_clr_en) slot_en[lk_idx] <= 1'b0;
          if (x_settmo) slot_tmo[lk_idx] <= clamp_tmo(cmd_arg);
          if (x_remove) begin
            slot_vld[lk_idx] <= 1'b0;
            slot_fid[lk_idx] <= '0;
            slot_en[lk_idx]  <= 1'b0;
            slot_st[lk_idx]  <= FS_RESERVED;
          end
          if (x_alloc) begin
            slot_vld[al_idx] <= 1'b1;
            slot_fid[al_idx] <= cmd_fid;
            slot_en[al_idx]  <= 1'b0;
            slot_tmo[al_idx] <= TMO_INIT;
            slot_st[al_idx]  <= cmd_arg[0] ? FS_STANDBY : FS_RESERVED;
            next_idx         <= al_idx + IDX_W'(1);
          end
          ctl <= C_IDLE;
        end
        C_EXP1: begin
          slot_st[exp_idx] <= FS_STANDBY;
          slot_en[exp_idx] <= 1'b0;
          evt_valid  <= 1'b1;
          evt_code   <= EV_CFG_TO_STBY;
          evt_fid    <= slot_fid[exp_idx];
          evt_handle <= {1'b0, exp_idx};
          dereg_irq  <= 1'b1;
          dereg_xlat <= 1'b1;
          dereg_fid  <= slot_fid[exp_idx];
          ctl        <= C_EXP2;
        end
        C_EXP2: begin
          evt_valid  <= 1'b1;
          evt_code   <= EV_STBY_TO_RSVD;
          evt_fid    <= slot_fid[exp_idx];
          evt_handle <= {1'b0, exp_idx};
          slot_vld[exp_idx] <= 1'b0;
          slot_fid[exp_idx] <= '0;
          slot_st[exp_idx]  <= FS_RESERVED;
          ctl        <= C_IDLE;
        end
        default: ctl <= C_IDLE;
      endcase
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done); // R3
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> $past(req_accept, 2)); // R3
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) req_accept |=> !req_ready); // R3
  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (ctl == C_EXEC && cmd_op == OP_ALLOC && al_ok) |-> !slot_vld[al_idx]); // R2
  AST_EXPIRY_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (evt_valid && evt_code == EV_CFG_TO_STBY) |=> (evt_valid && evt_code == EV_STBY_TO_RSVD)); // R8

endmodule

// File: tb/pcifn_state_ctrl_tb.sv
module pcifn_state_ctrl_tb;
  localparam int IDX_W = 2;
  localparam int FID_W = 8;
  localparam int TMR_W = 12;

  localparam logic [2:0] O_CFG = 3'd0, O_DECFG = 3'd1, O_RST = 3'd2, O_UNPLUG = 3'd3;
  localparam logic [2:0] O_ALLOC = 3'd4, O_EN = 3'd5, O_FAULT = 3'd6, O_TMO = 3'd7;
  localparam logic [15:0] K_OK = 16'h0010, K_NOACT = 16'h0020, K_RSVD = 16'h0030;
  localparam logic [15:0] K_UNK = 16'h0040, K_NOSLOT = 16'h0050, K_PEND = 16'h0060;
  localparam logic [15:0] E_REQ = 16'h0101, E_C2S = 16'h0102, E_S2R = 16'h0103;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [FID_W-1:0] req_fid = '0;
  logic [TMR_W-1:0] req_arg = '0;
  logic rsp_done;
  logic [15:0] rsp_code;
  logic [IDX_W:0] rsp_handle;
  logic evt_valid;
  logic [15:0] evt_code;
  logic [FID_W-1:0] evt_fid;
  logic [IDX_W:0] evt_handle;
  logic dereg_irq, dereg_xlat;
  logic [FID_W-1:0] dereg_fid;

  always #2 clk = ~clk;

  pcifn_state_ctrl #(.IDX_W(IDX_W), .FID_W(FID_W), .TMR_W(TMR_W), .TMO_DEF(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_fid(req_fid), .req_arg(req_arg),
    .rsp_done(rsp_done), .rsp_code(rsp_code), .rsp_handle(rsp_handle),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_fid(evt_fid), .evt_handle(evt_handle),
    .dereg_irq(dereg_irq), .dereg_xlat(dereg_xlat), .dereg_fid(dereg_fid)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] r_code, r_evt_code;
  logic [IDX_W:0] r_hnd;
  logic r_evt, r_irq, r_xlat, r_mid_ready, r_mid_done;
  logic [FID_W-1:0] r_evt_fid, r_dereg_fid;
  int r_lat;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [FID_W-1:0] fid, input logic [TMR_W-1:0] arg);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_fid = fid; req_arg = arg;
    r_lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    r_mid_ready = req_ready;
    r_mid_done = rsp_done;
    while (!rsp_done && r_lat < 8) begin
      @(negedge clk);
      r_lat++;
    end
    r_code = rsp_code; r_hnd = rsp_handle;
    r_evt = evt_valid; r_evt_code = evt_code; r_evt_fid = evt_fid;
    r_irq = dereg_irq; r_xlat = dereg_xlat; r_dereg_fid = dereg_fid;
  endtask

  task automatic expect_rsp(input string tag, input logic [15:0] code, input logic [IDX_W:0] hnd);
    chk(tag, "rsp_code", r_code, code);
    chk(tag, "rsp_handle", r_hnd, hnd);
  endtask

  function automatic logic [IDX_W:0] hd(input logic en, input int idx);
    return {en, IDX_W'(idx)};
  endfunction

  task automatic wait_evt(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!evt_valid && k < 300);
  endtask

  task automatic t_reset_state;
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "rsp_done", rsp_done, 0);
    chk("R1", "evt_valid", evt_valid, 0);
    chk("R1", "dereg", {dereg_irq, dereg_xlat}, 0);
    issue(O_CFG, 8'h11, 0);
    expect_rsp("R1", K_UNK, 0);
  endtask

  task automatic t_timing;
    issue(O_CFG, 8'h99, 0);
    chk("R3", "latency", r_lat, 2);
    chk("R3", "ready_between", r_mid_ready, 0);
    chk("R3", "done_early", r_mid_done, 0);
    @(negedge clk);
    chk("R3", "done_one_cycle", rsp_done, 0);
  endtask

  task automatic t_alloc_fill;
    issue(O_ALLOC, 8'h11, 1); expect_rsp("R2", K_OK, hd(0, 0));
    issue(O_ALLOC, 8'h22, 1); expect_rsp("R2", K_OK, hd(0, 1));
    issue(O_ALLOC, 8'h33, 0); expect_rsp("R2", K_OK, hd(0, 2));
    issue(O_ALLOC, 8'h11, 1); expect_rsp("R2", K_NOACT, hd(0, 0));
    issue(O_ALLOC, 8'h44, 1); expect_rsp("R2", K_OK, hd(0, 3));
    issue(O_ALLOC, 8'h55, 1); expect_rsp("R2", K_NOSLOT, 0);
  endtask

  task automatic t_configure;
    issue(O_CFG, 8'h33, 0); expect_rsp("R4", K_RSVD, hd(0, 2));
    issue(O_CFG, 8'h11, 0); expect_rsp("R4", K_OK, hd(0, 0));
    issue(O_CFG, 8'h11, 0); expect_rsp("R4", K_NOACT, hd(0, 0));
  endtask

  task automatic t_enable_fault;
    issue(O_EN, 8'h33, 0); expect_rsp("R11", K_RSVD, hd(0, 2));
    issue(O_EN, 8'h22, 0); expect_rsp("R11", K_NOACT, hd(0, 1));
    issue(O_FAULT, 8'h11, 0); expect_rsp("R12", K_NOACT, hd(0, 0));
    issue(O_EN, 8'h11, 0); expect_rsp("R11", K_OK, hd(1, 0));
    issue(O_EN, 8'h11, 0); expect_rsp("R11", K_NOACT, hd(1, 0));
    issue(O_FAULT, 8'h11, 0); expect_rsp("R12", K_OK, hd(1, 0));
    issue(O_FAULT, 8'h11, 0); expect_rsp("R12", K_OK, hd(1, 0));
    issue(O_FAULT, 8'h11, 0); expect_rsp("R12", K_NOACT, hd(1, 0));
    issue(O_FAULT, 8'h33, 0); expect_rsp("R12", K_RSVD, hd(0, 2));
  endtask

  task automatic t_reset_op;
    issue(O_RST, 8'h11, 0); expect_rsp("R10", K_OK, hd(0, 0));
    issue(O_RST, 8'h22, 0); expect_rsp("R10", K_NOACT, hd(0, 1));
    issue(O_CFG, 8'h22, 0); expect_rsp("R10", K_OK, hd(0, 1));
    issue(O_RST, 8'h33, 0); expect_rsp("R10", K_RSVD, hd(0, 2));
    issue(O_CFG, 8'h33, 0); expect_rsp("R10", K_RSVD, hd(0, 2));
    issue(O_CFG, 8'h11, 0); expect_rsp("R10", K_NOACT, hd(0, 0));
    issue(O_EN, 8'h11, 0); expect_rsp("R10", K_OK, hd(1, 0));
  endtask

  task automatic t_deconfig;
    issue(O_DECFG, 8'h11, 0); expect_rsp("R5", K_OK, hd(0, 0));
    chk("R5", "dereg", {r_irq, r_xlat}, 2'b11);
    chk("R5", "dereg_fid", r_dereg_fid, 8'h11);
    chk("R5", "no_event", r_evt, 0);
    issue(O_DECFG, 8'h11, 0); expect_rsp("R5", K_NOACT, hd(0, 0));
    chk("R5", "no_dereg", {r_irq, r_xlat}, 0);
    issue(O_DECFG, 8'h33, 0); expect_rsp("R5", K_RSVD, hd(0, 2));
    issue(O_CFG, 8'h11, 0); expect_rsp("R5", K_OK, hd(0, 0));
  endtask

  task automatic t_unplug_timeout(input logic [FID_W-1:0] fid, input int idx,
                                  input logic [TMR_W-1:0] set, input int t_eff);
    int k;
    issue(O_TMO, fid, set); expect_rsp("R13", K_OK, hd(0, idx));
    issue(O_UNPLUG, fid, 0); expect_rsp("R7", K_PEND, hd(0, idx));
    chk("R7", "evt_valid", r_evt, 1);
    chk("R7", "evt_code", r_evt_code, E_REQ);
    chk("R7", "evt_fid", r_evt_fid, fid);
    wait_evt(k);
    chk("R8", "expiry_delay", k, t_eff + 2);
    chk("R8", "evt_code", evt_code, E_C2S);
    chk("R8", "evt_fid", evt_fid, fid);
    chk("R8", "dereg", {dereg_irq, dereg_xlat}, 2'b11);
    @(negedge clk);
    chk("R8", "evt2_valid", evt_valid, 1);
    chk("R8", "evt2_code", evt_code, E_S2R);
    chk("R8", "evt2_handle", evt_handle, hd(0, idx));
    @(negedge clk);
    chk("R8", "evt_end", evt_valid, 0);
    issue(O_CFG, fid, 0); expect_rsp("R8", K_UNK, 0);
  endtask

  task automatic t_wrap_and_standby;
    issue(O_UNPLUG, 8'h33, 0); expect_rsp("R9", K_OK, hd(0, 2));
    chk("R9", "no_event", r_evt, 0);
    issue(O_ALLOC, 8'h66, 1); expect_rsp("R2", K_OK, hd(0, 0));
    issue(O_ALLOC, 8'h77, 1); expect_rsp("R2", K_OK, hd(0, 2));
    issue(O_DECFG, 8'h22, 0); expect_rsp("R9", K_OK, hd(0, 1));
    issue(O_UNPLUG, 8'h22, 0); expect_rsp("R9", K_OK, hd(0, 1));
    chk("R9", "evt_valid", r_evt, 1);
    chk("R9", "evt_code", r_evt_code, E_S2R);
    chk("R9", "evt_fid", r_evt_fid, 8'h22);
    issue(O_CFG, 8'h22, 0); expect_rsp("R9", K_UNK, 0);
  endtask

  task automatic t_unplug_then_deconfig;
    int seen;
    issue(O_CFG, 8'h44, 0); expect_rsp("R6", K_OK, hd(0, 3));
    issue(O_UNPLUG, 8'h44, 0); expect_rsp("R6", K_PEND, hd(0, 3));
    issue(O_DECFG, 8'h44, 0); expect_rsp("R6", K_OK, hd(0, 3));
    chk("R6", "evt_code", r_evt_valid_code(), {1'b1, E_S2R});
    chk("R6", "dereg", {r_irq, r_xlat}, 2'b11);
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (evt_valid) seen++;
    end
    chk("R6", "no_timeout_event", seen, 0);
    issue(O_CFG, 8'h44, 0); expect_rsp("R6", K_UNK, 0);
  endtask

  function automatic logic [16:0] r_evt_valid_code();
    return {r_evt, r_evt_code};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_timing();
    t_alloc_fill();
    t_configure();
    t_enable_fault();
    t_reset_op();
    t_deconfig();
    t_unplug_timeout(8'h11, 0, 12'd5, 5);
    t_wrap_and_standby();
    t_unplug_then_deconfig();
    issue(O_CFG, 8'h66, 0); expect_rsp("R4", K_OK, hd(0, 0));
    t_unplug_timeout(8'h66, 0, 12'd0, 1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule